// File: doc/BRIEF.md
# Fully Associative Tagged Translation Buffer

This block holds a small set of address translations, each tagged with a virtual page, a partition id, a context id and a flag that marks a real (partition-only) translation. Any entry can hold any page, and every lookup compares against all entries in parallel. Page sizes are 8 KB multiplied by a power of eight, selected per entry by a 2-bit size code (0: 8 KB, 1: 64 KB, 2: 512 KB, 3: 4 MB).

A lookup returns hit, the entry index and the translated physical address in the same cycle as its inputs. An insert writes one entry on the next clock edge. The entry is either a slot named by the caller or a slot the block chooses: a free slot if there is one, otherwise a round-robin pick that passes over locked slots. Three demap scopes remove entries: one page, one context, or every unlocked entry of a partition. A per-entry used flag is set on insert and on an opted-in lookup hit. The flags are exposed as a vector, and they are cleared in bulk when they would all be set.

The entry count is a parameter from 2 to 64, so that an index fits a 6-bit field. Other values stop elaboration.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, every lookup misses and `used_vec` is zero.
- R2: A lookup with `lk_real`=0 hits an entry only when the entry is valid and virtual, partition and context are equal, and the address bits at or above the entry's page size are equal. `lk_pa` is the entry's physical page with the lookup address bits below the page size. If several entries hit, the lowest index wins. The result is combinational.
- R3: A lookup with `lk_real`=1 hits only real entries, and it matches on partition and page with the context ignored.
- R4: An insert aligns its virtual and physical address down to its page size. On the next edge the written entry is valid and used.
- R5: An insert first invalidates every entry with the same real flag, partition and context whose page overlaps the new page, judged at the larger of the two page sizes.
- R6: With `ins_idx_en`=1 the insert writes slot `ins_idx`.
- R7: With `ins_idx_en`=0 and a free slot available (including one freed by R5), the lowest-index free slot is written.
- R8: With no free slot, the slots after the last round-robin victim are scanned in increasing index order with wraparound. The first unlocked slot is written and becomes the new last victim. The last victim is zero after reset.
- R9: If no other slot than the last victim is unlocked, slot ENTRIES-1 is written and the last victim is unchanged.
- R10: A hitting lookup with `lk_upd_used`=1 sets the hit entry's used flag on the next edge. With `lk_upd_used`=0 the used flags do not change. A used flag is never set on an invalid entry.
- R11: When an update would leave every used flag set, the used flags of all unlocked entries are cleared in that same update.
- R12: `dm_kind`=0 (page) removes entries that a lookup with the demap fields would hit. `dm_kind`=1 (context) removes every valid entry with equal partition and context, locked or not. Removed entries lose valid and used.
- R13: `dm_kind`=2 (all) removes every valid unlocked entry of `dm_part`. It leaves locked entries and other partitions untouched.
- R14: When `ins_en` and `dm_en` are both high, only the insert takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_part | input | PART_W | Lookup partition |
| lk_ctx | input | CTX_W | Lookup context |
| lk_real | input | 1 | Lookup is a real translation |
| lk_upd_used | input | 1 | Set the used flag of the hit entry |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the hit entry |
| lk_pa | output | PA_W | Translated physical address (zero on miss) |
| ins_en | input | 1 | Insert strobe |
| ins_va | input | VA_W | Insert virtual address |
| ins_pa | input | PA_W | Insert physical address |
| ins_part | input | PART_W | Insert partition |
| ins_ctx | input | CTX_W | Insert context |
| ins_real | input | 1 | Insert a real translation |
| ins_size | input | 2 | Page size code |
| ins_lock | input | 1 | Insert as locked |
| ins_idx_en | input | 1 | Use the explicit slot index |
| ins_idx | input | IDX_W | Explicit slot index |
| dm_en | input | 1 | Demap strobe |
| dm_kind | input | 2 | 0 page, 1 context, 2 all of partition |
| dm_va | input | VA_W | Demap page address |
| dm_part | input | PART_W | Demap partition |
| dm_ctx | input | CTX_W | Demap context |
| dm_real | input | 1 | Demap page targets real entries |
| used_vec | output | ENTRIES | Used flag per entry |

## Verification
Lookup results are combinational. The bench applies the lookup inputs after a falling edge and samples hit, index and address 1 ns later, with no clock edge between. Inserts, demaps and used-flag updates land on the first rising edge after the strobe. The bench raises each strobe at a falling edge and drops it at the next falling edge, then looks at `used_vec` or issues a lookup, so each such result is read one cycle after its stimulus. Victim choice is observed through the index a later lookup returns.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PG_SHIFT = 13;
  localparam int SZ_W     = 2;

  typedef enum logic [1:0] {
    DM_PAGE = 2'd0,
    DM_CTX  = 2'd1,
    DM_ALL  = 2'd2
  } dm_kind_e;

  // bits below the page boundary for a size code
  function automatic logic [63:0] page_mask(input logic [SZ_W-1:0] sz);
    return (64'd1 << (PG_SHIFT + 3 * int'(sz))) - 64'd1;
  endfunction

  function automatic logic va_eq(input logic [63:0] a, input logic [63:0] b,
                                 input logic [SZ_W-1:0] sz);
    return ((a ^ b) & ~page_mask(sz)) == 64'd0;
  endfunction
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp import tlb_pkg::*; #(
  parameter int VA_W   = 40,
  parameter int PART_W = 8,
  parameter int CTX_W  = 13
) (
  input  logic              e_valid,
  input  logic              e_real,
  input  logic              e_lock,
  input  logic [VA_W-1:0]   e_va,
  input  logic [PART_W-1:0] e_part,
  input  logic [CTX_W-1:0]  e_ctx,
  input  logic [SZ_W-1:0]   e_size,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [PART_W-1:0] lk_part,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic              lk_real,
  input  logic [VA_W-1:0]   ins_va,
  input  logic [PART_W-1:0] ins_part,
  input  logic [CTX_W-1:0]  ins_ctx,
  input  logic              ins_real,
  input  logic [SZ_W-1:0]   ins_size,
  input  logic [1:0]        dm_kind,
  input  logic [VA_W-1:0]   dm_va,
  input  logic [PART_W-1:0] dm_part,
  input  logic [CTX_W-1:0]  dm_ctx,
  input  logic              dm_real,
  output logic              lk_match,
  output logic              ins_conflict,
  output logic              dm_match
);
  logic [SZ_W-1:0] big_sz;
  logic            dm_page_m;

  assign big_sz = (e_size > ins_size) ? e_size : ins_size;

  assign lk_match = e_valid && (e_part == lk_part) && (e_real == lk_real) &&
                    (lk_real || (e_ctx == lk_ctx)) &&
                    va_eq(64'(e_va), 64'(lk_va), e_size);

  assign ins_conflict = e_valid && (e_real == ins_real) && (e_part == ins_part) &&
                        (e_ctx == ins_ctx) && va_eq(64'(e_va), 64'(ins_va), big_sz);

  assign dm_page_m = e_valid && (e_part == dm_part) && (e_real == dm_real) &&
                     (dm_real || (e_ctx == dm_ctx)) &&
                     va_eq(64'(e_va), 64'(dm_va), e_size);

  always_comb begin
    unique case (dm_kind)
      DM_PAGE: dm_match = dm_page_m;
      DM_CTX:  dm_match = e_valid && (e_part == dm_part) && (e_ctx == dm_ctx);
      DM_ALL:  dm_match = e_valid && !e_lock && (e_part == dm_part);
      default: dm_match = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               ins_idx_en,
  input  logic [IDX_W-1:0]   ins_idx,
  input  logic [ENTRIES-1:0] free_vec,
  input  logic [ENTRIES-1:0] lock_vec,
  input  logic [IDX_W-1:0]   last_idx,
  output logic [IDX_W-1:0]   vic_idx,
  output logic               rr_take
);
  logic             any_free, rr_found;
  logic [IDX_W-1:0] free_idx, rr_idx;

  // lowest free slot
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // rotating scan after the last victim, skipping locked slots
  always_comb begin
    int j;
    rr_found = 1'b0;
    rr_idx   = '0;
    j        = 0;
    for (int k = 1; k < ENTRIES; k++) begin
      j = (int'(last_idx) + k) % ENTRIES;
      if (!rr_found && !lock_vec[j]) begin
        rr_found = 1'b1;
        rr_idx   = IDX_W'(j);
      end
    end
  end

  always_comb begin
    rr_take = 1'b0;
    if (ins_idx_en)    vic_idx = ins_idx;
    else if (any_free) vic_idx = free_idx;
    else if (rr_found) begin
      vic_idx = rr_idx;
      rr_take = 1'b1;
    end
    else vic_idx = IDX_W'(ENTRIES - 1);
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa import tlb_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 40,
  parameter int PA_W    = 40,
  parameter int PART_W  = 8,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [PART_W-1:0]  lk_part,
  input  logic [CTX_W-1:0]   lk_ctx,
  input  logic               lk_real,
  input  logic               lk_upd_used,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [PA_W-1:0]    lk_pa,
  input  logic               ins_en,
  input  logic [VA_W-1:0]    ins_va,
  input  logic [PA_W-1:0]    ins_pa,
  input  logic [PART_W-1:0]  ins_part,
  input  logic [CTX_W-1:0]   ins_ctx,
  input  logic               ins_real,
  input  logic [1:0]         ins_size,
  input  logic               ins_lock,
  input  logic               ins_idx_en,
  input  logic [IDX_W-1:0]   ins_idx,
  input  logic               dm_en,
  input  logic [1:0]         dm_kind,
  input  logic [VA_W-1:0]    dm_va,
  input  logic [PART_W-1:0]  dm_part,
  input  logic [CTX_W-1:0]   dm_ctx,
  input  logic               dm_real,
  output logic [ENTRIES-1:0] used_vec
);
  if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_size
    $error("tlb_fa: ENTRIES must be within 2..64");
  end

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic [ENTRIES-1:0] valid_q, used_q, lock_q, real_q;
  logic [ENTRIES-1:0] valid_d, used_d, lock_d, real_d;
  logic [VA_W-1:0]    va_q   [ENTRIES];
  logic [PA_W-1:0]    pa_q   [ENTRIES];
  logic [PART_W-1:0]  part_q [ENTRIES];
  logic [CTX_W-1:0]   ctx_q  [ENTRIES];
  logic [SZ_W-1:0]    size_q [ENTRIES];
  logic [IDX_W-1:0]   last_q, last_d;

  logic [ENTRIES-1:0] lk_m, conf, dm_m;
  logic [IDX_W-1:0]   vic_idx;
  logic               rr_take, upd_hit, state_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlb_entry_cmp #(.VA_W(VA_W), .PART_W(PART_W), .CTX_W(CTX_W)) i_cmp (
      .e_valid(valid_q[g]), .e_real(real_q[g]), .e_lock(lock_q[g]),
      .e_va(va_q[g]), .e_part(part_q[g]), .e_ctx(ctx_q[g]), .e_size(size_q[g]),
      .lk_va(lk_va), .lk_part(lk_part), .lk_ctx(lk_ctx), .lk_real(lk_real),
      .ins_va(ins_va), .ins_part(ins_part), .ins_ctx(ins_ctx),
      .ins_real(ins_real), .ins_size(ins_size),
      .dm_kind(dm_kind), .dm_va(dm_va), .dm_part(dm_part), .dm_ctx(dm_ctx),
      .dm_real(dm_real),
      .lk_match(lk_m[g]), .ins_conflict(conf[g]), .dm_match(dm_m[g])
    );
  end

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_victim (
    .ins_idx_en(ins_idx_en), .ins_idx(ins_idx),
    .free_vec(~valid_q | conf), .lock_vec(lock_q), .last_idx(last_q),
    .vic_idx(vic_idx), .rr_take(rr_take)
  );

  // lookup: lowest matching index
  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_m[i]) begin
        lk_hit = 1'b1;
        lk_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    logic [63:0] m;
    m = page_mask(size_q[lk_idx]);
    lk_pa = lk_hit ? PA_W'((64'(pa_q[lk_idx]) & ~m) | (64'(lk_va) & m)) : '0;
  end

  assign upd_hit  = lk_upd_used && lk_hit;
  assign state_en = ins_en || dm_en || upd_hit;
  assign used_vec = used_q;

  // next state of the flag vectors
  always_comb begin
    valid_d = valid_q;
    used_d  = used_q;
    lock_d  = lock_q;
    real_d  = real_q;
    last_d  = last_q;
    if (upd_hit) used_d[lk_idx] = 1'b1;
    if (ins_en) begin
      valid_d          = valid_d & ~conf;
      used_d           = used_d & ~conf;
      valid_d[vic_idx] = 1'b1;
      used_d[vic_idx]  = 1'b1;
      lock_d[vic_idx]  = ins_lock;
      real_d[vic_idx]  = ins_real;
      if (rr_take) last_d = vic_idx;
    end else if (dm_en) begin
      valid_d = valid_d & ~dm_m;
      used_d  = used_d & ~dm_m;
    end
    if (&used_d) used_d = used_d & lock_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      valid_q <= '0;
      used_q  <= '0;
      lock_q  <= '0;
      real_q  <= '0;
      last_q  <= '0;
    end else if (state_en) begin
      valid_q <= valid_d;
      used_q  <= used_d;
      lock_q  <= lock_d;
      real_q  <= real_d;
      last_q  <= last_d;
    end
  end

  // tag and payload fields: written only at the victim slot
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        va_q[i]   <= '0;
        pa_q[i]   <= '0;
        part_q[i] <= '0;
        ctx_q[i]  <= '0;
        size_q[i] <= '0;
      end
    end else if (ins_en) begin
      va_q[vic_idx]   <= VA_W'(64'(ins_va) & ~page_mask(ins_size));
      pa_q[vic_idx]   <= PA_W'(64'(ins_pa) & ~page_mask(ins_size));
      part_q[vic_idx] <= ins_part;
      ctx_q[vic_idx]  <= ins_ctx;
      size_q[vic_idx] <= ins_size;
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_en,
  input logic               ins_idx_en,
  input logic [IDX_W-1:0]   ins_idx,
  input logic               dm_en,
  input logic [1:0]         dm_kind,
  input logic               lk_hit,
  input logic [IDX_W-1:0]   lk_idx,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] used_q,
  input logic [ENTRIES-1:0] lock_q,
  input logic [IDX_W-1:0]   vic_idx,
  input logic               rr_take
);
  p_hit_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> valid_q[lk_idx]);

  p_ins_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> valid_q[$past(vic_idx)]);

  p_explicit_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && ins_idx_en) |=> valid_q[$past(ins_idx)]);

  p_rr_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && rr_take) |-> !lock_q[vic_idx]);

  p_used_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q & ~valid_q) == '0);

  p_never_all_used_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~lock_q)) |-> !(&used_q));

  p_dmall_keeps_locked_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_en && !ins_en && dm_kind == 2'd2) |=> (($past(valid_q & lock_q) & ~valid_q) == '0));
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_idx_en(ins_idx_en),
  .ins_idx(ins_idx), .dm_en(dm_en), .dm_kind(dm_kind), .lk_hit(lk_hit),
  .lk_idx(lk_idx), .valid_q(valid_q), .used_q(used_q), .lock_q(lock_q),
  .vic_idx(vic_idx), .rr_take(rr_take)
);

// File: tb/test_tlb_fa.sv
`timescale 1ns/1ps
module test_tlb_fa;
  localparam int ENTRIES = 8;
  localparam int VA_W = 40, PA_W = 40, PART_W = 8, CTX_W = 13;
  localparam int IDX_W = $clog2(ENTRIES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [VA_W-1:0] lk_va = '0, ins_va = '0, dm_va = '0;
  logic [PART_W-1:0] lk_part = '0, ins_part = '0, dm_part = '0;
  logic [CTX_W-1:0] lk_ctx = '0, ins_ctx = '0, dm_ctx = '0;
  logic lk_real = 0, lk_upd_used = 0, ins_en = 0, ins_real = 0, ins_lock = 0;
  logic ins_idx_en = 0, dm_en = 0, dm_real = 0;
  logic [PA_W-1:0] ins_pa = '0;
  logic [1:0] ins_size = '0, dm_kind = '0;
  logic [IDX_W-1:0] ins_idx = '0;
  logic lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic [PA_W-1:0] lk_pa;
  logic [ENTRIES-1:0] used_vec;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlb_fa i_tlb_fa (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] xpa(input logic [63:0] va, input logic [63:0] pa,
                                      input int sz);
    logic [63:0] m;
    m = (64'd1 << (13 + 3 * sz)) - 64'd1;
    return (pa & ~m) | (va & m);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ins(input logic [63:0] va, input logic [63:0] pa, input int part,
                     input int ctx, input bit rl, input int sz, input bit lk,
                     input bit xen, input int xi);
    @(negedge clk);
    ins_va = VA_W'(va); ins_pa = PA_W'(pa); ins_part = PART_W'(part);
    ins_ctx = CTX_W'(ctx); ins_real = rl; ins_size = 2'(sz); ins_lock = lk;
    ins_idx_en = xen; ins_idx = IDX_W'(xi); ins_en = 1'b1;
    @(negedge clk);
    ins_en = 1'b0; ins_idx_en = 1'b0;
  endtask

  task automatic dmp(input int kind, input logic [63:0] va, input int part,
                     input int ctx, input bit rl);
    @(negedge clk);
    dm_kind = 2'(kind); dm_va = VA_W'(va); dm_part = PART_W'(part);
    dm_ctx = CTX_W'(ctx); dm_real = rl; dm_en = 1'b1;
    @(negedge clk);
    dm_en = 1'b0;
  endtask

  task automatic probe(input logic [63:0] va, input int part, input int ctx,
                       input bit rl, output logic h, output logic [63:0] idx,
                       output logic [63:0] pa);
    @(negedge clk);
    lk_va = VA_W'(va); lk_part = PART_W'(part); lk_ctx = CTX_W'(ctx);
    lk_real = rl; lk_upd_used = 1'b0;
    #1;
    h = lk_hit; idx = 64'(lk_idx); pa = 64'(lk_pa);
  endtask

  task automatic touch(input logic [63:0] va, input int part, input int ctx, input bit upd);
    @(negedge clk);
    lk_va = VA_W'(va); lk_part = PART_W'(part); lk_ctx = CTX_W'(ctx);
    lk_real = 1'b0; lk_upd_used = upd;
    @(negedge clk);
    lk_upd_used = 1'b0;
  endtask

  function automatic logic [63:0] fva(input int i);
    return 64'(i) << 13;
  endfunction

  task automatic fill(input logic [7:0] locks);
    for (int i = 0; i < ENTRIES; i++)
      ins(fva(i), 64'h80_0000_0000 | fva(i), 1, 1, 0, 0, locks[i], 0, 0);
  endtask

  task automatic t_reset();
    logic h; logic [63:0] x, p;
    do_reset();
    chk("R1 used_vec", 64'(used_vec), 0);
    probe(0, 0, 0, 0, h, x, p);
    chk("R1 miss", 64'(h), 0);
  endtask

  task automatic t_basic();
    logic h; logic [63:0] x, p;
    do_reset();
    ins(64'h00_1234_5678, 64'h00_ABCD_E123, 1, 5, 0, 0, 0, 0, 0);
    chk("R4 used after insert", 64'(used_vec), 64'h1);
    probe(64'h00_1234_5ABC, 1, 5, 0, h, x, p);
    chk("R2 hit", 64'(h), 1);
    chk("R7 slot", x, 0);
    chk("R2 R4 pa", p, xpa(64'h00_1234_5ABC, 64'h00_ABCD_E123, 0));
    probe(64'h00_1234_3FFF, 1, 5, 0, h, x, p);
    chk("R4 below aligned page misses", 64'(h), 0);
    probe(64'h00_1234_5ABC, 1, 6, 0, h, x, p);
    chk("R2 context mismatch", 64'(h), 0);
    probe(64'h00_1234_5ABC, 2, 5, 0, h, x, p);
    chk("R2 partition mismatch", 64'(h), 0);
    probe(64'h00_1234_5ABC, 1, 5, 1, h, x, p);
    chk("R3 real lookup misses virtual entry", 64'(h), 0);
  endtask

  task automatic t_real();
    logic h; logic [63:0] x, p;
    do_reset();
    ins(64'h00_0042_0000, 64'h00_7700_0000, 2, 7, 1, 1, 0, 0, 0);
    probe(64'h00_0042_F00D, 2, 99, 1, h, x, p);
    chk("R3 real hit any ctx", 64'(h), 1);
    chk("R3 pa 64K page", p, xpa(64'h00_0042_F00D, 64'h00_7700_0000, 1));
  endtask

  task automatic t_conflict();
    logic h; logic [63:0] x, p;
    do_reset();
    ins(64'h00_0010_0000, 64'h1_0000, 1, 1, 0, 0, 0, 0, 0);
    ins(64'h00_0010_2000, 64'h2_0000, 1, 1, 0, 0, 0, 0, 0);
    ins(64'h00_0010_2000, 64'h3_0000, 1, 2, 0, 0, 0, 0, 0);
    ins(64'h00_0010_0000, 64'h40_0000, 1, 1, 0, 1, 0, 1, 5);
    chk("R5 R6 used_vec", 64'(used_vec), 64'h24);
    probe(64'h00_0010_2010, 1, 1, 0, h, x, p);
    chk("R6 explicit slot", x, 5);
    chk("R5 new pa", p, xpa(64'h00_0010_2010, 64'h40_0000, 1));
    probe(64'h00_0010_2010, 1, 2, 0, h, x, p);
    chk("R5 other ctx kept", x, 2);
  endtask

  task automatic t_free();
    logic h; logic [63:0] x, p;
    do_reset();
    for (int i = 0; i < 3; i++) ins(fva(i), fva(i), 1, 1, 0, 0, 0, 0, 0);
    dmp(0, fva(1), 1, 1, 0);
    ins(fva(20), fva(20), 1, 1, 0, 0, 0, 0, 0);
    probe(fva(20), 1, 1, 0, h, x, p);
    chk("R7 lowest free", x, 1);
  endtask

  task automatic t_rr();
    logic h; logic [63:0] x, p;
    do_reset();
    fill(8'b0000_0110);
    ins(fva(40), 0, 1, 1, 0, 0, 0, 0, 0);
    probe(fva(40), 1, 1, 0, h, x, p);
    chk("R8 skip locked", x, 3);
    ins(fva(41), 0, 1, 1, 0, 0, 0, 0, 0);
    probe(fva(41), 1, 1, 0, h, x, p);
    chk("R8 advance", x, 4);
  endtask

  task automatic t_alllocked();
    logic h; logic [63:0] x, p;
    do_reset();
    fill(8'hFF);
    ins(fva(50), 0, 1, 1, 0, 0, 0, 0, 0);
    probe(fva(50), 1, 1, 0, h, x, p);
    chk("R9 last slot", x, ENTRIES - 1);
    probe(fva(7), 1, 1, 0, h, x, p);
    chk("R9 old entry gone", 64'(h), 0);
  endtask

  task automatic t_used();
    do_reset();
    fill(8'h00);
    chk("R11 rollover clears", 64'(used_vec), 0);
    touch(fva(2), 1, 1, 0);
    chk("R10 no update", 64'(used_vec), 0);
    touch(fva(2), 1, 1, 1);
    chk("R10 update", 64'(used_vec), 64'h04);
    do_reset();
    fill(8'h01);
    chk("R11 locked kept", 64'(used_vec), 64'h01);
  endtask

  task automatic t_demap();
    logic h; logic [63:0] x, p;
    do_reset();
    ins(64'h4_0000, 0, 1, 1, 0, 0, 0, 0, 0);
    ins(64'h4_0000, 0, 1, 2, 0, 0, 0, 0, 0);
    ins(64'h8_0000, 0, 2, 1, 0, 0, 0, 0, 0);
    ins(64'hC_0000, 0, 1, 1, 0, 0, 1, 0, 0);
    ins(64'h10_0000, 0, 1, 1, 0, 0, 0, 0, 0);
    dmp(0, 64'h4_0100, 1, 1, 0);
    probe(64'h4_0000, 1, 1, 0, h, x, p);
    chk("R12 page removed", 64'(h), 0);
    probe(64'h4_0000, 1, 2, 0, h, x, p);
    chk("R12 page other ctx", x, 1);
    dmp(1, 0, 1, 1, 0);
    probe(64'hC_0000, 1, 1, 0, h, x, p);
    chk("R12 ctx removes locked", 64'(h), 0);
    probe(64'h10_0000, 1, 1, 0, h, x, p);
    chk("R12 ctx removes", 64'(h), 0);
    probe(64'h8_0000, 2, 1, 0, h, x, p);
    chk("R12 other partition kept", 64'(h), 1);
    do_reset();
    ins(fva(0), 0, 1, 1, 0, 0, 1, 0, 0);
    ins(fva(1), 0, 1, 1, 0, 0, 0, 0, 0);
    ins(fva(2), 0, 2, 1, 0, 0, 0, 0, 0);
    dmp(2, 0, 1, 0, 0);
    probe(fva(0), 1, 1, 0, h, x, p);
    chk("R13 locked kept", 64'(h), 1);
    probe(fva(1), 1, 1, 0, h, x, p);
    chk("R13 unlocked removed", 64'(h), 0);
    probe(fva(2), 2, 1, 0, h, x, p);
    chk("R13 other partition kept", 64'(h), 1);
  endtask

  task automatic t_prio();
    logic h; logic [63:0] x, p;
    do_reset();
    ins(fva(0), 0, 1, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    dm_kind = 2'd2; dm_part = 8'd1; dm_en = 1'b1;
    ins_va = VA_W'(fva(3)); ins_pa = '0; ins_part = 8'd1; ins_ctx = 13'd1;
    ins_real = 0; ins_size = 0; ins_lock = 0; ins_idx_en = 0; ins_en = 1'b1;
    @(negedge clk);
    dm_en = 1'b0; ins_en = 1'b0;
    probe(fva(0), 1, 1, 0, h, x, p);
    chk("R14 demap ignored", 64'(h), 1);
    probe(fva(3), 1, 1, 0, h, x, p);
    chk("R14 insert done", x, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_real();
    t_conflict();
    t_free();
    t_rr();
    t_alllocked();
    t_used();
    t_demap();
    t_prio();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule